// File: doc/BRIEF.md
# SPI Master Transfer Engine with Run/Halt Sequencer

This block is an SPI master that shifts words out of a four-entry transmit queue and stores what comes back in a four-entry receive queue. Frames run MSB first. The serial clock idles low, data is sampled on its rising edge and changed on its falling edge, and the clock runs at the system clock divided by a fixed even divisor. Chip select stays low for the whole frame. The frame length can be set from 4 to 16 bits. Short frames use the low bits of a transmit entry and come back right-justified in the receive entry.

A three-state sequencer (reset, stopped, running) decides whether frames may begin. Three things block transfers: a halt control, a sticky end-of-queue flag, and a freeze request that counts only while a debug indication is present. A stop request never cuts a frame short. The current frame completes, and the sequencer leaves the running state only at the frame boundary. If no frame is active, it stops on the next clock. Each transmit entry carries a marker bit. When a marked frame finishes, the end-of-queue flag is set, and the flag stays set until it is cleared with a one-cycle pulse.

Top module: `spi_seq_master`

## Requirements
- R1: When reset is asserted, `running` is 0, `cs_n` is 1, `sclk` is 0, both queues are empty and `eoq_flag` is 0. On the first clock after reset is released the sequencer enters the stopped state, so `running` is still 0 after that edge.
- R2: The sequencer moves from stopped to running on a clock edge only if all three hold: `halt` is 0, `eoq_flag` is 0, and `dbg_mode` and `frz_en` are not both 1.
- R3: While running, any one blocking condition requests a stop: `halt` is 1, `eoq_flag` is 1, or `dbg_mode` and `frz_en` are both 1. `dbg_mode` alone does not stop the engine.
- R4: A stop request made during a frame takes effect on the clock after the frame ends, and `running` stays 1 until then. A stop request made with no frame active clears `running` on the next clock.
- R5: `running` is 1 exactly while the sequencer is in the running state.
- R6: The frame length is `frame_len`, sampled when the frame starts. Values below 4 are treated as 4 and values above 16 as 16. The engine sends bits [len-1:0] of the entry, MSB first, and `mosi` is 0 outside a frame.
- R7: Frames start only when `cfg_mode` equals 2'b00. With any other value no new frame begins.
- R8: A frame starts only when the sequencer is running, no stop is requested, the transmit queue is non-empty, the receive queue is not full and no frame is active. After each frame, `cs_n` is high for at least one cycle.
- R9: During a frame, `cs_n` is low for exactly len × CLK_DIV cycles. `sclk` starts low, toggles every CLK_DIV/2 cycles, and is 0 whenever `cs_n` is 1. `miso` is sampled on each rising `sclk` edge.
- R10: Each completed frame pushes one receive entry holding the sampled bits, right-justified with zeros above them. `rx_data` shows the oldest entry.
- R11: A frame popped with `tx_eoq`=1 sets `eoq_flag` on its final clock. An `eoq_clr` pulse clears the flag, and setting wins if both happen in the same cycle.
- R12: Each queue holds 4 entries in order. A push into a full transmit queue is dropped, and a pop from an empty receive queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Configuration select; 2'b00 enables SPI shifting |
| frame_len | input | 5 | Frame length in bits, clamped to 4..16 |
| halt | input | 1 | Stop request from software |
| dbg_mode | input | 1 | Debug mode indication |
| frz_en | input | 1 | Freeze-on-debug enable |
| eoq_clr | input | 1 | Clear pulse for the end-of-queue flag |
| tx_push | input | 1 | Transmit queue write strobe |
| tx_data | input | 16 | Transmit word |
| tx_eoq | input | 1 | End-of-queue marker stored with the word |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_pop | input | 1 | Receive queue read strobe |
| rx_data | output | 16 | Oldest receive entry |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| eoq_flag | output | 1 | Sticky end-of-queue flag |
| running | output | 1 | Sequencer status: 1 while running |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The engine is first driven with 8-bit words whose upper bits are set. This shows whether the length field masks those bits and whether MSB-first order and the right-justified capture are correct. Frame lengths of 2, 20 and 12 are then used. Counting chip-select cycles for these shows the difference between correct clamping and a length used as given. Halt is raised both during a frame and while idle, and freeze is applied with and without the debug indication, to tell a stop at the frame boundary from an abort and to show that a missing condition blocks the stop. A stalled receive queue, an overfilled transmit queue, a non-zero mode field and a marked entry followed by a clear pulse check the start gating and the end-of-queue sequence.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
   typedef enum logic [1:0] {
      SEQ_RESET   = 2'b00,
      SEQ_STOPPED = 2'b01,
      SEQ_RUNNING = 2'b10
   } seq_state_e;

   localparam logic [1:0] MODE_SPI = 2'b00;
   localparam int         MIN_FRAME_BITS = 4;
endpackage

// File: rtl/spi_seq_fifo.sv
module spi_seq_fifo #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             full,
   output logic             empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [WIDTH-1:0] store [DEPTH];
   logic [AW-1:0]    wptr, rptr, wptr_nx, rptr_nx;
   logic [CW-1:0]    level;
   logic             do_push, do_pop;

   assign full    = (level == CW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign rdata   = store[rptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wptr_nx = wptr + 1'b1;
         assign rptr_nx = rptr + 1'b1;
      end else begin : g_mod
         assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) store[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (do_push) wptr <= wptr_nx;
         if (do_pop)  rptr <= rptr_nx;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/spi_seq_runctl.sv
module spi_seq_runctl
   import spi_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic halt,
   input  logic dbg_mode,
   input  logic frz_en,
   input  logic eoq_clr,
   input  logic frame_busy,
   input  logic done_eoq,
   output logic running,
   output logic stop_req,
   output logic eoq_flag
);
   seq_state_e state_q;

   assign stop_req = eoq_flag | halt | (dbg_mode & frz_en);
   assign running  = (state_q == SEQ_RUNNING);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_RESET;
      end else begin
         unique case (state_q)
            SEQ_RESET:   state_q <= SEQ_STOPPED;
            SEQ_STOPPED: if (!stop_req) state_q <= SEQ_RUNNING;
            SEQ_RUNNING: if (stop_req && !frame_busy) state_q <= SEQ_STOPPED;
            default:     state_q <= SEQ_STOPPED;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        eoq_flag <= 1'b0;
      else if (done_eoq) eoq_flag <= 1'b1;
      else if (eoq_clr)  eoq_flag <= 1'b0;
   end
endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter #(
   parameter int DATA_W  = 16,
   parameter int CLK_DIV = 4,
   parameter int LEN_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] load_word,
   input  logic [LEN_W-1:0]  load_len,
   input  logic              load_eoq,
   input  logic              miso,
   output logic              busy,
   output logic              done,
   output logic              done_eoq,
   output logic [DATA_W-1:0] rx_word,
   output logic              sclk,
   output logic              mosi,
   output logic              cs_n
);
   localparam int HALF = CLK_DIV / 2;

   logic              sclk_q, eoq_q, half_end, last_bit;
   logic [LEN_W-1:0]  len_q, bit_q;
   logic [DATA_W-1:0] tx_sh, rx_sh;

   generate
      if (HALF == 1) begin : g_fast
         assign half_end = 1'b1;
      end else begin : g_count
         localparam int HW = $clog2(HALF);
         logic [HW-1:0] hcnt;
         assign half_end = (hcnt == HW'(HALF - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                hcnt <= '0;
            else if (start || !busy)   hcnt <= '0;
            else if (half_end)         hcnt <= '0;
            else                       hcnt <= hcnt + 1'b1;
         end
      end
   endgenerate

   assign last_bit = (bit_q == len_q - 1'b1);
   assign done     = busy & half_end & sclk_q & last_bit;
   assign done_eoq = done & eoq_q;
   assign rx_word  = rx_sh;
   assign sclk     = sclk_q;
   assign mosi     = busy & tx_sh[DATA_W-1];
   assign cs_n     = ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         sclk_q <= 1'b0;
         eoq_q  <= 1'b0;
         len_q  <= LEN_W'(DATA_W);
         bit_q  <= '0;
         tx_sh  <= '0;
         rx_sh  <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         sclk_q <= 1'b0;
         eoq_q  <= load_eoq;
         len_q  <= load_len;
         bit_q  <= '0;
         tx_sh  <= load_word << (LEN_W'(DATA_W) - load_len);
         rx_sh  <= '0;
      end else if (busy && half_end) begin
         if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_sh  <= {rx_sh[DATA_W-2:0], miso};
         end else if (last_bit) begin
            sclk_q <= 1'b0;
            busy   <= 1'b0;
         end else begin
            sclk_q <= 1'b0;
            tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
            bit_q  <= bit_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_seq_master.sv
module spi_seq_master
   import spi_seq_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int FIFO_DEPTH = 4,
   parameter int CLK_DIV    = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   cfg_mode,
   input  logic [$clog2(DATA_W+1)-1:0]  frame_len,
   input  logic                         halt,
   input  logic                         dbg_mode,
   input  logic                         frz_en,
   input  logic                         eoq_clr,
   input  logic                         tx_push,
   input  logic [DATA_W-1:0]            tx_data,
   input  logic                         tx_eoq,
   output logic                         tx_full,
   output logic                         tx_empty,
   input  logic                         rx_pop,
   output logic [DATA_W-1:0]            rx_data,
   output logic                         rx_full,
   output logic                         rx_empty,
   output logic                         eoq_flag,
   output logic                         running,
   output logic                         sclk,
   output logic                         cs_n,
   output logic                         mosi,
   input  logic                         miso
);
   localparam int LEN_W = $clog2(DATA_W + 1);
   localparam int TXW   = DATA_W + 1;

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (DATA_W < MIN_FRAME_BITS) begin : g_bad_width
         $error("DATA_W must be at least the minimum frame length");
      end
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 2");
      end
   endgenerate

   logic [TXW-1:0]    tx_head;
   logic [DATA_W-1:0] rx_word;
   logic [LEN_W-1:0]  len_eff;
   logic              start, busy, done, done_eoq, stop_req;

   always_comb begin
      if (frame_len < LEN_W'(MIN_FRAME_BITS))  len_eff = LEN_W'(MIN_FRAME_BITS);
      else if (frame_len > LEN_W'(DATA_W))     len_eff = LEN_W'(DATA_W);
      else                                     len_eff = frame_len;
   end

   assign start = running & ~stop_req & ~busy & (cfg_mode == MODE_SPI)
                & ~tx_empty & ~rx_full;

   spi_seq_fifo #(.WIDTH(TXW), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_push),
      .wdata ({tx_eoq, tx_data}),
      .pop   (start),
      .rdata (tx_head),
      .full  (tx_full),
      .empty (tx_empty)
   );

   spi_seq_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (done),
      .wdata (rx_word),
      .pop   (rx_pop),
      .rdata (rx_data),
      .full  (rx_full),
      .empty (rx_empty)
   );

   spi_seq_runctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .halt       (halt),
      .dbg_mode   (dbg_mode),
      .frz_en     (frz_en),
      .eoq_clr    (eoq_clr),
      .frame_busy (busy),
      .done_eoq   (done_eoq),
      .running    (running),
      .stop_req   (stop_req),
      .eoq_flag   (eoq_flag)
   );

   spi_seq_shifter #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV), .LEN_W(LEN_W)) u_shf (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .load_word (tx_head[DATA_W-1:0]),
      .load_len  (len_eff),
      .load_eoq  (tx_head[DATA_W]),
      .miso      (miso),
      .busy      (busy),
      .done      (done),
      .done_eoq  (done_eoq),
      .rx_word   (rx_word),
      .sclk      (sclk),
      .mosi      (mosi),
      .cs_n      (cs_n)
   );
endmodule

// File: rtl/spi_seq_master_chk.sv
module spi_seq_master_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] cfg_mode,
   input logic       halt,
   input logic       dbg_mode,
   input logic       frz_en,
   input logic       eoq_flag,
   input logic       running,
   input logic       cs_n,
   input logic       sclk,
   input logic       tx_full,
   input logic       tx_empty,
   input logic       rx_full,
   input logic       rx_empty
);
   assert_reset_stopped_R1: assert property (@(posedge clk)
      !rst_n |=> !running);

   assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> $past(!halt && !eoq_flag && !(dbg_mode && frz_en)));

   assert_stop_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> $past(halt || eoq_flag || (dbg_mode && frz_en)));

   assert_stop_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> $past(cs_n));

   assert_mode_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode != 2'b00 && cs_n) |=> cs_n);

   assert_frame_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> $past(running && !tx_empty && !rx_full));

   assert_idle_clock_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   assert_queue_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_full && tx_empty) && !(rx_full && rx_empty));
endmodule

bind spi_seq_master spi_seq_master_chk chk_i (.*);

// File: tb/spi_seq_master_tb_top.sv
`timescale 1ns/1ps
module spi_seq_master_tb_top;
   localparam int DIV  = 4;
   localparam int HALF = DIV / 2;
   localparam int DEP  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_mode = 2'b00;
   logic [4:0]  frame_len = 5'd8;
   logic        halt = 1'b0, dbg_mode = 1'b0, frz_en = 1'b0, eoq_clr = 1'b0;
   logic        tx_push = 1'b0, tx_eoq = 1'b0, rx_pop = 1'b0, miso = 1'b0;
   logic [15:0] tx_data = '0;
   logic        tx_full, tx_empty, rx_full, rx_empty, eoq_flag, running;
   logic        sclk, cs_n, mosi;
   logic [15:0] rx_data;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   spi_seq_master #(.DATA_W(16), .FIFO_DEPTH(DEP), .CLK_DIV(DIV)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .frame_len(frame_len),
      .halt(halt), .dbg_mode(dbg_mode), .frz_en(frz_en), .eoq_clr(eoq_clr),
      .tx_push(tx_push), .tx_data(tx_data), .tx_eoq(tx_eoq),
      .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop),
      .rx_data(rx_data), .rx_full(rx_full), .rx_empty(rx_empty),
      .eoq_flag(eoq_flag), .running(running), .sclk(sclk), .cs_n(cs_n),
      .mosi(mosi), .miso(miso)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference model
   int          m_state = 0;
   bit          m_busy = 0, m_eoq = 0, m_mark = 0;
   int          m_t = 0, m_len = 4;
   logic [15:0] m_word = '0, m_rx = '0;
   logic [16:0] txq[$];
   logic [15:0] rxq[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_busy = 0; m_eoq = 0; m_t = 0;
         txq.delete(); rxq.delete();
      end else begin
         bit stopc, go, fin;
         int nt, tx_n, rx_n;
         logic [16:0] e;
         stopc = m_eoq || halt || (dbg_mode && frz_en);
         tx_n  = txq.size();
         rx_n  = rxq.size();
         go    = (m_state == 2) && !stopc && !m_busy && (cfg_mode == 2'b00)
                 && tx_n > 0 && rx_n < DEP;
         fin   = 0;
         if (m_busy) begin
            nt = m_t + 1;
            if (nt % DIV == HALF) m_rx = {m_rx[14:0], miso};
            if (nt == m_len * DIV) begin fin = 1; end
            else m_t = nt;
         end
         if (rx_pop && rx_n > 0) void'(rxq.pop_front());
         if (fin) rxq.push_back(m_rx);
         if (fin && m_mark) m_eoq = 1;
         else if (eoq_clr)  m_eoq = 0;
         case (m_state)
            0: m_state = 1;
            1: if (!stopc) m_state = 2;
            default: if (stopc && !m_busy) m_state = 1;
         endcase
         if (fin) m_busy = 0;
         if (go) begin
            e = txq.pop_front();
            m_busy = 1; m_t = 0; m_rx = '0;
            m_word = e[15:0]; m_mark = e[16];
            m_len  = (frame_len < 4) ? 4 : (frame_len > 16) ? 16 : int'(frame_len);
         end
         if (tx_push && tx_n < DEP) txq.push_back({tx_eoq, tx_data});
      end
   end

   // Per-cycle comparison and miso stimulus, away from the active edge
   int unsigned lfsr = 32'h1d2c3b4a;
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R5 running", running, m_state == 2);
         check("R9 cs_n", cs_n, !m_busy);
         check("R9 sclk", sclk, m_busy && ((m_t / HALF) % 2 == 1));
         check("R6 mosi", mosi, m_busy ? m_word[m_len - 1 - m_t / DIV] : 1'b0);
         check("R12 tx_full", tx_full, txq.size() == DEP);
         check("R12 tx_empty", tx_empty, txq.size() == 0);
         check("R12 rx_full", rx_full, rxq.size() == DEP);
         check("R12 rx_empty", rx_empty, rxq.size() == 0);
         check("R11 eoq_flag", eoq_flag, m_eoq);
         if (rxq.size() > 0) check("R10 rx_data", rx_data, rxq[0]);
      end
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      miso = lfsr[7];
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_word(input logic [15:0] d, input logic mk);
      tx_push = 1'b1; tx_data = d; tx_eoq = mk;
      @(negedge clk);
      tx_push = 1'b0; tx_eoq = 1'b0;
   endtask

   task automatic pop_word();
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
   endtask

   task automatic wait_quiet();
      for (int i = 0; i < 4000; i++) begin
         if (tx_empty && cs_n) break;
         @(negedge clk);
      end
      idle(2);
   endtask

   task automatic drain();
      for (int i = 0; i < 6000; i++) begin
         if (tx_empty && cs_n && rx_empty) break;
         if (!rx_empty) pop_word();
         else @(negedge clk);
      end
   endtask

   task automatic frame_cycles(input logic [4:0] len, input int exp, input string tag);
      int cnt = 0;
      frame_len = len;
      push_word(16'h9e37, 1'b0);
      for (int i = 0; i < 200 && cs_n; i++) @(negedge clk);
      while (!cs_n && cnt < 500) begin cnt++; @(negedge clk); end
      check(tag, cnt, exp);
      wait_quiet();
      drain();
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: one clock after release the sequencer is only stopped
      check("R1 running after release", running, 1'b0);
      check("R1 cs_n idle", cs_n, 1'b1);
      check("R1 sclk idle", sclk, 1'b0);
      check("R1 queues empty", {tx_empty, rx_empty}, 2'b11);
      check("R1 eoq clear", eoq_flag, 1'b0);
      @(negedge clk);
      check("R2 enters running", running, 1'b1);

      // Main function, 8-bit frames with upper bits set (R6, R10)
      frame_len = 5'd8;
      push_word(16'h00a5, 1'b0);
      push_word(16'h3c3c, 1'b0);
      push_word(16'hfff1, 1'b0);
      wait_quiet();
      drain();

      // Length clamping and frame duration (R6, R9)
      frame_cycles(5'd2,  4 * DIV,  "R6 len below min clamps to 4");
      frame_cycles(5'd20, 16 * DIV, "R6 len above max clamps to 16");
      frame_cycles(5'd12, 12 * DIV, "R9 cs_n low for len*div");

      // Stop during a frame waits for the boundary (R4)
      frame_len = 5'd16;
      push_word(16'h1234, 1'b0);
      push_word(16'h5678, 1'b0);
      for (int i = 0; i < 100 && cs_n; i++) @(negedge clk);
      idle(3);
      halt = 1'b1;
      idle(2);
      check("R4 running kept mid-frame", {running, cs_n}, 2'b10);
      for (int i = 0; i < 200 && !cs_n; i++) @(negedge clk);
      check("R4 running at boundary", running, 1'b1);
      @(negedge clk);
      check("R4 stopped after boundary", running, 1'b0);
      idle(20);
      check("R3 halt holds queued word", tx_empty, 1'b0);
      halt = 1'b0;
      wait_quiet();
      drain();

      // Stop with no frame in progress (R4) and restart (R2)
      halt = 1'b1;
      @(negedge clk);
      check("R4 idle stop next clock", running, 1'b0);
      halt = 1'b0;
      @(negedge clk);
      check("R2 restart when clear", running, 1'b1);

      // Freeze only counts with debug mode (R3)
      dbg_mode = 1'b1;
      idle(2);
      check("R3 debug without freeze runs", running, 1'b1);
      frz_en = 1'b1;
      @(negedge clk);
      check("R3 debug with freeze stops", running, 1'b0);
      dbg_mode = 1'b0;
      @(negedge clk);
      check("R2 restart after debug", running, 1'b1);
      frz_en = 1'b0;

      // Non-SPI configuration blocks shifting (R7)
      cfg_mode = 2'b10;
      frame_len = 5'd6;
      push_word(16'h002b, 1'b0);
      idle(30);
      check("R7 no frame in other mode", {cs_n, tx_empty}, 2'b10);
      cfg_mode = 2'b00;
      wait_quiet();
      drain();

      // Receive queue full stalls; transmit overflow dropped (R8, R12)
      frame_len = 5'd4;
      for (int i = 0; i < 5; i++) push_word(16'(i * 3 + 5), 1'b0);
      for (int i = 0; i < 400 && !rx_full; i++) @(negedge clk);
      idle(30);
      check("R8 full rx queue blocks start", {rx_full, tx_empty, cs_n}, 3'b101);
      for (int i = 0; i < 4; i++) push_word(16'(i + 8'h40), 1'b0);
      check("R12 tx queue full", tx_full, 1'b1);
      push_word(16'hdead, 1'b0);
      drain();

      // End-of-queue marker stops after its frame; clear restarts (R11)
      frame_len = 5'd8;
      push_word(16'h0011, 1'b0);
      push_word(16'h0022, 1'b1);
      push_word(16'h0033, 1'b0);
      for (int i = 0; i < 400 && !eoq_flag; i++) @(negedge clk);
      @(negedge clk);
      check("R11 stop after marked frame", {running, tx_empty}, 2'b00);
      idle(10);
      check("R11 flag sticky", eoq_flag, 1'b1);
      eoq_clr = 1'b1;
      @(negedge clk);
      eoq_clr = 1'b0;
      check("R11 clear pulse", eoq_flag, 1'b0);
      wait_quiet();
      check("R11 remaining word sent", tx_empty, 1'b1);
      drain();
      pop_word();
      check("R12 pop of empty ignored", rx_empty, 1'b1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule